// File: doc/BRIEF.md
# Role-Assigned CPU Register File

This block is a compact file of 16-bit registers where every register has a fixed job in the processor. It holds a program counter, seven index registers, an extension accumulator, a quotient register, a base register and three interrupt vector words. One write port and one read port are both addressed by a 4-bit register selector. The read port is combinational and shows the value as it stood before the current clock edge. The write port takes effect on the rising edge.

Beside plain storage, the file does three things on its own. It steps the program counter by one each time the control logic reports a completed instruction. It joins the externally held accumulator with the extension register to form a 32-bit double-precision operand, with the extension as the low half. It also drives a dedicated vector output with the interrupt address for the interrupt class being serviced. Instruction decode, arithmetic and memory sit outside the block. The accumulator enters only as an input for the 32-bit pairing.

Top module: `role_regfile`

## Requirements
- R1: After reset, every selector reads 0x0000, `pc_o` is 0x0000, `vector_o` is 0x0000 for every class, and the low half of `dword_o` is 0x0000.
- R2: Selector encodings are 0 program counter, 1 to 7 index registers, 8 extension, 9 quotient, 10 base, 11 service vector, 12 internal-error vector, 13 power-fail/trace vector. A word written with `wr_en_i` high to selector 0 to 13 reads back on `rd_data_o` from the cycle after the edge.
- R3: Selectors 14 and 15 always read 0x0000. A write to them changes no register and no output.
- R4: While `step_i` is high and the program counter is not being written, `pc_o` rises by one at each edge, wrapping from 0xFFFF to 0x0000. Otherwise it holds.
- R5: A write to selector 0 in the same cycle as `step_i` loads the written value, and the increment is dropped.
- R6: A write to any selector other than 0 in the same cycle as `step_i` performs both the write and the increment.
- R7: `dword_o` is {`acc_i`, extension register}: bits 31:16 follow `acc_i` combinationally and bits 15:0 hold selector 8.
- R8: `vector_o` shows selector 11 for `irq_class_i`=0, selector 12 for 1, selector 13 for 2, and 0x0000 for 3.
- R9: `pc_o` always equals the value read at selector 0.
- R10: Reading the selector being written in the same cycle returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 4 | Write register selector |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 4 | Read register selector |
| rd_data_o | output | 16 | Read data (pre-edge value) |
| step_i | input | 1 | Instruction completed: advance program counter |
| pc_o | output | 16 | Program counter |
| acc_i | input | 16 | Accumulator, upper half of the paired operand |
| dword_o | output | 32 | Accumulator joined with the extension register |
| irq_class_i | input | 2 | Interrupt class being serviced |
| vector_o | output | 16 | Interrupt address for that class |

## Verification
The program counter can be written through the port and stepped in the same cycle. That collision decides whether the file acts as a jump target or as a sequencer. The bench drives it on purpose: it writes selector 0 with `step_i` high, at mid-range values and at 0xFFFF. The expected counter then comes from a behavioural model in which the write overrides the step. Writes to other selectors with `step_i` high are mixed in to show that both effects land. A long random phase raises both strobes often, and every cycle is compared against the model.

// File: rtl/role_regfile_pkg.sv
`timescale 1ns/1ps
package role_regfile_pkg;

    // Selector geometry
    localparam int SEL_W      = 4;
    localparam int NUM_INDEX  = 7;
    localparam int NUM_VEC    = 3;

    // Bank holds every register except the program counter
    localparam int BANK_WORDS = NUM_INDEX + 3 + NUM_VEC;

    // Selector values (behaviour depends on these encodings)
    localparam logic [SEL_W-1:0] SEL_PC       = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_EXT      = SEL_W'(NUM_INDEX + 1);
    localparam logic [SEL_W-1:0] SEL_QUO      = SEL_W'(NUM_INDEX + 2);
    localparam logic [SEL_W-1:0] SEL_BASE     = SEL_W'(NUM_INDEX + 3);
    localparam logic [SEL_W-1:0] SEL_VEC0     = SEL_W'(NUM_INDEX + 4);
    localparam logic [SEL_W-1:0] SEL_RSV_LO   = SEL_W'(BANK_WORDS + 1);

    // Bank index of the extension word and of the first vector word
    localparam int EXT_IDX    = NUM_INDEX;
    localparam int VEC_IDX    = NUM_INDEX + 3;

    typedef enum logic [1:0] {
        IRQ_SERVICE = 2'd0,
        IRQ_FAULT   = 2'd1,
        IRQ_POWER   = 2'd2,
        IRQ_NONE    = 2'd3
    } irq_class_e;

endpackage

// File: rtl/rrf_pc_unit.sv
`timescale 1ns/1ps
// Program counter with load-over-step priority.
module rrf_pc_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] pc_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // explicit load wins over the step
            st_d.pc = load_data_i;
        end else if (step_i) begin
            st_d.pc = st_q.pc + DATA_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

endmodule

// File: rtl/rrf_word_bank.sv
`timescale 1ns/1ps
// Storage for all non-PC registers; one decoded write enable per word.
module rrf_word_bank
    import role_regfile_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WORDS  = BANK_WORDS
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [SEL_W-1:0]             wr_sel_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output logic [WORDS-1:0][DATA_W-1:0] words_o
);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] word;
    } bank_state_t;

    bank_state_t      st_d, st_q;
    logic [WORDS-1:0] hit;

    // Bank word g answers to selector g+1; selectors past the bank never hit
    for (genvar g = 0; g < WORDS; g++) begin : g_decode
        assign hit[g] = wr_en_i && (wr_sel_i == SEL_W'(g + 1));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WORDS; i++) begin
            if (hit[i]) begin
                st_d.word[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words_o = st_q.word;

endmodule

// File: rtl/rrf_port_mux.sv
`timescale 1ns/1ps
// Read-port selection, vector selection and double-word pairing.
module rrf_port_mux
    import role_regfile_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WORDS  = BANK_WORDS
) (
    input  logic [DATA_W-1:0]            pc_i,
    input  logic [WORDS-1:0][DATA_W-1:0] words_i,
    input  logic [SEL_W-1:0]             rd_sel_i,
    input  logic [1:0]                   irq_class_i,
    input  logic [DATA_W-1:0]            acc_i,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [DATA_W-1:0]            vector_o,
    output logic [2*DATA_W-1:0]          dword_o
);

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i == SEL_PC) begin
            rd_data_o = pc_i;
        end
        for (int i = 0; i < WORDS; i++) begin
            if (rd_sel_i == SEL_W'(i + 1)) begin
                rd_data_o = words_i[i];
            end
        end
    end

    always_comb begin
        vector_o = '0;
        for (int c = 0; c < NUM_VEC; c++) begin
            if (irq_class_i == 2'(c)) begin
                vector_o = words_i[VEC_IDX + c];
            end
        end
    end

    // extension word is always the low half
    assign dword_o = {acc_i, words_i[EXT_IDX]};

endmodule

// File: rtl/role_regfile.sv
`timescale 1ns/1ps
module role_regfile
    import role_regfile_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [3:0]          wr_sel_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [3:0]          rd_sel_i,
    output logic [DATA_W-1:0]   rd_data_o,
    input  logic                step_i,
    output logic [DATA_W-1:0]   pc_o,
    input  logic [DATA_W-1:0]   acc_i,
    output logic [2*DATA_W-1:0] dword_o,
    input  logic [1:0]          irq_class_i,
    output logic [DATA_W-1:0]   vector_o
);

    logic                              pc_load;
    logic [DATA_W-1:0]                 pc_q;
    logic [BANK_WORDS-1:0][DATA_W-1:0] bank_words;

    assign pc_load = wr_en_i && (wr_sel_i == SEL_PC);

    rrf_pc_unit #(.DATA_W(DATA_W)) i_pc (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (pc_load),
        .load_data_i (wr_data_i),
        .step_i      (step_i),
        .pc_o        (pc_q)
    );

    rrf_word_bank #(.DATA_W(DATA_W), .WORDS(BANK_WORDS)) i_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .words_o   (bank_words)
    );

    rrf_port_mux #(.DATA_W(DATA_W), .WORDS(BANK_WORDS)) i_mux (
        .pc_i        (pc_q),
        .words_i     (bank_words),
        .rd_sel_i    (rd_sel_i),
        .irq_class_i (irq_class_i),
        .acc_i       (acc_i),
        .rd_data_o   (rd_data_o),
        .vector_o    (vector_o),
        .dword_o     (dword_o)
    );

    assign pc_o = pc_q;

endmodule

// File: rtl/role_regfile_chk.sv
`timescale 1ns/1ps
module role_regfile_chk #(
    parameter int DATA_W = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                wr_en_i,
    input logic [3:0]          wr_sel_i,
    input logic [DATA_W-1:0]   wr_data_i,
    input logic [3:0]          rd_sel_i,
    input logic [DATA_W-1:0]   rd_data_o,
    input logic                step_i,
    input logic [DATA_W-1:0]   pc_o,
    input logic [2*DATA_W-1:0] dword_o,
    input logic [1:0]          irq_class_i,
    input logic [DATA_W-1:0]   vector_o
);

    logic pc_wr;
    assign pc_wr = wr_en_i && (wr_sel_i == 4'd0);

    p_pc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !pc_wr) |=> (pc_o == $past(pc_o) + DATA_W'(1)));

    p_pc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !pc_wr) |=> $stable(pc_o));

    p_pc_write_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_wr |=> (pc_o == $past(wr_data_i)));

    p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_sel_i >= 4'd14) |-> (rd_data_o == '0));

    p_pc_port_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_sel_i == 4'd0) |-> (rd_data_o == pc_o));

    p_ext_low_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_sel_i == 4'd8) |-> (dword_o[DATA_W-1:0] == rd_data_o));

    p_vec_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_class_i == 2'd3) |-> (vector_o == '0));

    p_vec_service_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_class_i == 2'd0 && rd_sel_i == 4'd11) |-> (vector_o == rd_data_o));

endmodule

bind role_regfile role_regfile_chk #(.DATA_W(DATA_W)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .step_i      (step_i),
    .pc_o        (pc_o),
    .dword_o     (dword_o),
    .irq_class_i (irq_class_i),
    .vector_o    (vector_o)
);

// File: tb/test_role_regfile.sv
`timescale 1ns/1ps
module test_role_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        step = 1'b0;
    logic [15:0] pc;
    logic [15:0] acc = '0;
    logic [31:0] dword;
    logic [1:0]  irq_class = '0;
    logic [15:0] vec;

    int total = 0;
    int bad = 0;
    int mdl [16];   // behavioural reference: one integer per selector

    always #2 clk = ~clk;   // 250 MHz

    role_regfile i_role_regfile (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .step_i(step), .pc_o(pc), .acc_i(acc), .dword_o(dword),
        .irq_class_i(irq_class), .vector_o(vec)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, compare combinational outputs against the model,
    // take the edge, then advance the model.
    task automatic cycle(input bit we, input int ws, input int wd,
                         input int rs, input bit st, input int ac,
                         input int cl, input string rd_tag, input string pc_tag);
        int exp_vec;
        string tag;
        wr_en = we; wr_sel = 4'(ws); wr_data = 16'(wd);
        rd_sel = 4'(rs); step = st; acc = 16'(ac); irq_class = 2'(cl);
        #1;
        tag = rd_tag;
        if (tag == "") tag = (rs >= 14) ? "R3" : "R2";
        check(tag, "rd_data", rd_data, mdl[rs]);
        check(pc_tag, "pc_o", pc, mdl[0]);
        check("R9", "pc_vs_sel0", pc, mdl[0]);
        check("R7", "dword", dword, {16'(ac), 16'(mdl[8])});
        exp_vec = (cl < 3) ? mdl[11 + cl] : 0;
        check("R8", "vector", vec, exp_vec);
        @(posedge clk);
        if (we && ws == 0) begin
            mdl[0] = wd & 16'hFFFF;
        end else begin
            if (st) mdl[0] = (mdl[0] + 1) & 16'hFFFF;
            if (we && ws < 14) mdl[ws] = wd & 16'hFFFF;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        foreach (mdl[i]) mdl[i] = 0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything zero after reset
        for (int s = 0; s < 16; s++) cycle(0, 0, 0, s, 0, 16'h1234, s % 4, "R1", "R1");

        // R2: write and read back each named register
        for (int s = 1; s < 14; s++) cycle(1, s, 16'hA000 + s * 16'h0111, 0, 0, 0, 3, "", "R4");
        for (int s = 0; s < 14; s++) cycle(0, 0, 0, s, 0, 16'h5A5A, 0, "R2", "R4");

        // R3: writes to reserved selectors leave everything untouched
        cycle(1, 14, 16'hDEAD, 14, 0, 0, 1, "R3", "R4");
        cycle(1, 15, 16'hBEEF, 15, 0, 0, 2, "R3", "R4");
        for (int s = 0; s < 16; s++) cycle(0, 0, 0, s, 0, 0, 3, "R3", "R4");

        // R8: each interrupt class
        for (int c = 0; c < 4; c++) cycle(0, 0, 0, 11 + (c % 3), 0, 0, c, "R8", "R4");

        // R4: stepping and wrap
        cycle(1, 0, 16'hFFFD, 0, 0, 0, 0, "R4", "R4");
        for (int k = 0; k < 5; k++) cycle(0, 0, 0, 0, 1, 0, 0, "R4", "R4");

        // R5: write to PC collides with step, write wins (also at 0xFFFF)
        cycle(1, 0, 16'h4000, 0, 1, 0, 0, "R5", "R5");
        cycle(0, 0, 0, 0, 0, 0, 0, "R5", "R5");
        cycle(1, 0, 16'hFFFF, 0, 1, 0, 0, "R5", "R5");
        cycle(0, 0, 0, 0, 1, 0, 0, "R5", "R5");

        // R6: write elsewhere plus step, both land
        cycle(1, 9, 16'h0C0C, 9, 1, 0, 0, "R6", "R6");
        cycle(0, 0, 0, 9, 0, 0, 0, "R6", "R6");

        // R10: read of the register written this cycle shows the old value
        cycle(1, 5, 16'h7777, 5, 0, 0, 0, "R10", "R4");
        cycle(1, 5, 16'h8888, 5, 0, 0, 0, "R10", "R4");
        cycle(0, 0, 0, 5, 0, 0, 0, "R10", "R4");

        // R7: accumulator pairing with fresh extension
        cycle(1, 8, 16'h00FF, 8, 0, 16'hABCD, 0, "R7", "R4");
        cycle(0, 0, 0, 8, 0, 16'h1357, 0, "R7", "R4");

        // Random collision-heavy phase
        for (int n = 0; n < 4000; n++) begin
            cycle(($urandom % 3) != 0, int'($urandom % 16), int'($urandom % 65536),
                  int'($urandom % 16), ($urandom % 2) != 0, int'($urandom % 65536),
                  int'($urandom % 4), "", "R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule